// File: doc/BRIEF.md
# Serial-Loaded Quad Wiper Register Bank

This block is the digital control core of a four-channel digitally set resistor. A three-wire serial port (clock, data in, active-low select) fills a 10-bit frame register. When select returns high, the two leading bits of the frame pick one of four 8-bit wiper registers and the trailing eight bits become that channel's code. Code 0x00 puts the wiper at the B end and 0xFF at the A end, in 256 linear steps. A serial output taken from the far end of the frame register lets several blocks share one port as a daisy chain.

The serial pins are oversampled by the system clock through synchronizers, so any number of these blocks can sit in one clock domain. A preset input forces every channel to midscale (0x80). A shutdown input drives per-channel switch controls that open the A terminal and tie the wiper to B. Shutdown leaves the stored codes and the serial port untouched, so channels can be reprogrammed while shut down and resume with the latest code.

Top module: `serial_wiper_bank`

## Requirements
- R1: A frame is shifted in MSB first while `cs_n` is low, one bit per rising `sclk` edge. On the rising edge of `cs_n` the first two bits received (frame bits 9:8) form the channel address and the last eight (bits 7:0) the code. Address k loads `wiper_codes[8k+7:8k]`.
- R2: A frame load changes only the addressed channel; the other three codes keep their values.
- R3: If more than ten bits were clocked in one select window, only the last ten received are decoded.
- R4: While `rst_n` is low at a `clk` edge, every code becomes 0x80 and `sdo` becomes 0.
- R5: While `preset_n` is low at a `clk` edge, every code becomes 0x80. This takes priority over a frame load in the same cycle.
- R6: With `shdn_n` low, every bit of `a_open` and `wiper_to_b` is 1 in the same cycle; with `shdn_n` high they are all 0.
- R7: Shutdown never alters the stored codes. Frames written during shutdown load normally and stay in effect after release.
- R8: `sdo` changes only on a falling `sclk` edge, where it takes frame bit 9. Two blocks chained `sdo` to `sdi`, sent 20 bits in one select window, load the first ten bits into the far block and the last ten into the near one.
- R9: `sclk` edges while `cs_n` is high do not shift the frame register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| preset_n | input | 1 | Active-low preset of all codes to midscale |
| shdn_n | input | 1 | Active-low shutdown of the resistor switches |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| sdo | output | 1 | Serial data out for daisy chaining |
| wiper_codes | output | 32 | Four 8-bit wiper codes, channel k at bits 8k+7:8k |
| a_open | output | 4 | Per channel: open the A terminal |
| wiper_to_b | output | 4 | Per channel: short the wiper to B |

## Verification
Two functions can fall in the same `clk` cycle: the frame load triggered by the detected rise of `cs_n` and the midscale preset. The bench holds `preset_n` low across a whole frame, including its closing select edge, and expects every channel at 0x80 afterwards. The checker requires midscale after any cycle with preset active, whatever the load strobe did. Shutdown overlapping a write is also provoked: a frame is written while `shdn_n` is low, and the bench expects the new code both during and after shutdown.

// File: rtl/wiper_pkg.sv
// Shared types and defaults for the serial wiper register bank.
package wiper_pkg;
    // Synchronizer depth on the serial pins (must be at least 2).
    localparam int SYNC_DEPTH = 2;

    // Serial events detected in the system clock domain.
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_rise;
        logic cs_active;
    } ser_evt_t;
endpackage

// File: rtl/serial_frontend.sv
// Synchronizes sclk, sdi and cs_n into clk and flags their edges.
// Assumes each serial level lasts several clk periods.
module serial_frontend
    import wiper_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    input  logic     sdi,
    input  logic     cs_n,
    output ser_evt_t evt,
    output logic     sdi_s
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sdi_q;
    logic              sclk_d;
    logic              cs_d;
    logic              sclk_s;
    logic              cs_s;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            sdi_q  <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            sdi_q  <= {sdi_q[STAGES-2:0], sdi};
            sclk_d <= sclk_q[STAGES-1];
            cs_d   <= cs_q[STAGES-1];
        end
    end

    assign sclk_s = sclk_q[STAGES-1];
    assign cs_s   = cs_q[STAGES-1];
    assign sdi_s  = sdi_q[STAGES-1];

    // Edge strobes, one clk cycle wide.
    always_comb begin
        evt.sclk_rise = sclk_s & ~sclk_d;
        evt.sclk_fall = ~sclk_s & sclk_d;
        evt.cs_rise   = cs_s & ~cs_d;
        evt.cs_active = ~cs_s;
    end
endmodule

// File: rtl/frame_shifter.sv
// Frame shift register: shifts on sclk rise while selected and
// presents its far end on sdo after each sclk fall.
module frame_shifter #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               fall_stb,
    input  logic               sdi_s,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    // Shift new bits in at the LSB; oldest bit ends at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame <= '0;
        else if (shift_en) frame <= {frame[FRAME_W-2:0], sdi_s};
    end

    // Serial output updates on the falling serial edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo <= 1'b0;
        else if (fall_stb) sdo <= frame[FRAME_W-1];
    end
endmodule

// File: rtl/code_bank.sv
// Holds one wiper code per channel. Reset and preset both load
// midscale; preset wins over a load arriving in the same cycle.
module code_bank #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        data,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    // Per-channel update: reset, then preset, then addressed load.
    always_ff @(posedge clk) begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (!rst_n || !preset_n)
                codes[ch*CODE_W +: CODE_W] <= MID;
            else if (load && addr == ADDR_W'(ch))
                codes[ch*CODE_W +: CODE_W] <= data;
        end
    end
endmodule

// File: rtl/serial_wiper_bank.sv
// Top of the serial wiper register bank: front end, frame register,
// code bank and combinational shutdown switch controls.
module serial_wiper_bank
    import wiper_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset_n,
    input  logic                     shdn_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     cs_n,
    output logic                     sdo,
    output logic [NUM_CH*CODE_W-1:0] wiper_codes,
    output logic [NUM_CH-1:0]        a_open,
    output logic [NUM_CH-1:0]        wiper_to_b
);
    localparam int ADDR_W  = $clog2(NUM_CH);
    localparam int FRAME_W = ADDR_W + CODE_W;

    ser_evt_t           evt;
    logic               sdi_s;
    logic [FRAME_W-1:0] frame;
    logic               frame_done;
    logic               fall_stb;

    serial_frontend #(.STAGES(SYNC_DEPTH)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .cs_n  (cs_n),
        .evt   (evt),
        .sdi_s (sdi_s)
    );

    assign frame_done = evt.cs_rise;
    assign fall_stb   = evt.sclk_fall;

    frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (evt.sclk_rise & evt.cs_active),
        .fall_stb (fall_stb),
        .sdi_s    (sdi_s),
        .frame    (frame),
        .sdo      (sdo)
    );

    code_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_n (preset_n),
        .load     (frame_done),
        .addr     (frame[FRAME_W-1 -: ADDR_W]),
        .data     (frame[CODE_W-1:0]),
        .codes    (wiper_codes)
    );

    // Shutdown switch controls, one pair per channel, no register.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sw
        assign a_open[g]     = ~shdn_n;
        assign wiper_to_b[g] = ~shdn_n;
    end
endmodule

// File: rtl/serial_wiper_bank_chk.sv
// Property checker for serial_wiper_bank, attached by bind.
module serial_wiper_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     preset_n,
    input logic                     shdn_n,
    input logic                     frame_done,
    input logic                     fall_stb,
    input logic                     sdo,
    input logic [NUM_CH*CODE_W-1:0] wiper_codes,
    input logic [NUM_CH-1:0]        a_open,
    input logic [NUM_CH-1:0]        wiper_to_b
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [NUM_CH*CODE_W-1:0] prev_codes;
    logic [NUM_CH-1:0]        chg;
    logic                     all_mid;

    // Last cycle's codes, for per-channel change detection.
    always_ff @(posedge clk) prev_codes <= wiper_codes;

    // Which channels differ from last cycle, and whether all are midscale.
    always_comb begin
        all_mid = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            chg[c] = wiper_codes[c*CODE_W +: CODE_W] != prev_codes[c*CODE_W +: CODE_W];
            if (wiper_codes[c*CODE_W +: CODE_W] != MID) all_mid = 1'b0;
        end
    end

    // R5
    preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |=> all_mid);

    // R2
    single_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && preset_n) |=> ($countones(chg) <= 1));

    // R7
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && preset_n) |=> $stable(wiper_codes));

    // R8
    sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(sdo));

    // R6
    switch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_open == wiper_to_b) && ($countones(a_open) == (shdn_n ? 0 : NUM_CH)));
endmodule

bind serial_wiper_bank serial_wiper_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .preset_n    (preset_n),
    .shdn_n      (shdn_n),
    .frame_done  (frame_done),
    .fall_stb    (fall_stb),
    .sdo         (sdo),
    .wiper_codes (wiper_codes),
    .a_open      (a_open),
    .wiper_to_b  (wiper_to_b)
);

// File: tb/serial_wiper_bank_test.sv
// Self-checking bench: directed corners plus seeded random frames.
module serial_wiper_bank_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, preset_n, preset2_n, shdn_n, sclk, sdi, cs_n;
    logic        sdo, sdo2;
    logic [31:0] codes1, codes2;
    logic [3:0]  aop1, wtb1, aop2, wtb2;
    logic [7:0]  exp1 [4];
    logic [7:0]  exp2 [4];
    int          vectors = 0;
    int          misses  = 0;
    bit          done    = 1'b0;

    serial_wiper_bank uut (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .shdn_n(shdn_n),
        .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .sdo(sdo),
        .wiper_codes(codes1), .a_open(aop1), .wiper_to_b(wtb1));

    serial_wiper_bank uut2 (
        .clk(clk), .rst_n(rst_n), .preset_n(preset2_n), .shdn_n(1'b1),
        .sclk(sclk), .sdi(sdo), .cs_n(cs_n), .sdo(sdo2),
        .wiper_codes(codes2), .a_open(aop2), .wiper_to_b(wtb2));

    function automatic logic [31:0] mk(input int a, input logic [7:0] d);
        logic [1:0] a2 = a[1:0];
        return {22'b0, a2, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic chk_bank1(input string req);
        for (int c = 0; c < 4; c++) chk(req, {24'b0, codes1[c*8 +: 8]}, {24'b0, exp1[c]});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            tick(8); sclk = 1'b1;
            tick(8); sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] w, input int n);
        cs_n = 1'b0; tick(8);
        shift_bits(w, n);
        tick(8); cs_n = 1'b1; tick(8);
    endtask

    task automatic write1(input int a, input logic [7:0] d);
        frame(mk(a, d), 10);
        exp1[a] = d;
    endtask

    task automatic all_mid1();
        for (int c = 0; c < 4; c++) exp1[c] = 8'h80;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        rst_n = 1'b0; preset_n = 1'b1; preset2_n = 1'b1; shdn_n = 1'b1;
        sclk = 1'b0; sdi = 1'b0; cs_n = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        all_mid1();
        chk_bank1("R4");
        chk("R4", {31'b0, sdo}, 32'h0);
        chk("R6", {28'b0, aop1}, 32'h0);

        // R1: every address, with boundary codes
        write1(0, 8'h12); chk_bank1("R1");
        write1(1, 8'h00); chk_bank1("R1");
        write1(2, 8'hFF); chk_bank1("R1");
        write1(3, 8'hC3); chk_bank1("R1");

        // R2: seeded random frames, untouched channels must hold
        for (int k = 0; k < 40; k++) begin
            int a = int'($urandom % 4);
            logic [7:0] d = 8'($urandom);
            write1(a, d);
            chk_bank1("R2");
        end

        // R3: 14 bits clocked, last ten decoded
        frame({18'b0, 4'b1101, 2'd2, 8'h3C}, 14);
        exp1[2] = 8'h3C;
        chk_bank1("R3");

        // R9: clocks with select high must not shift
        write1(1, 8'hA5);
        preset_n = 1'b0; tick(2); preset_n = 1'b1; tick(2);
        all_mid1();
        chk_bank1("R5");
        shift_bits(mk(2, 8'h5A), 10);
        cs_n = 1'b0; tick(8); cs_n = 1'b1; tick(8);
        exp1[1] = 8'hA5;
        chk_bank1("R9");

        // R5: preset held across a frame's closing edge wins
        preset_n = 1'b0;
        frame(mk(0, 8'h11), 10);
        preset_n = 1'b1; tick(4);
        all_mid1();
        chk_bank1("R5");

        // R6 and R7: shutdown with a write made while shut
        write1(0, 8'h42);
        @(negedge clk); shdn_n = 1'b0; #1;
        chk("R6", {28'b0, aop1}, 32'hF);
        chk("R6", {28'b0, wtb1}, 32'hF);
        chk_bank1("R7");
        write1(3, 8'hE7);
        chk_bank1("R7");
        chk("R6", {28'b0, aop1}, 32'hF);
        @(negedge clk); shdn_n = 1'b1; #1;
        chk("R6", {28'b0, aop1}, 32'h0);
        chk("R6", {28'b0, wtb1}, 32'h0);
        tick(4);
        chk_bank1("R7");

        // R8: two-block chain, 20 bits in one window
        preset2_n = 1'b0; tick(2); preset2_n = 1'b1; tick(2);
        for (int c = 0; c < 4; c++) exp2[c] = 8'h80;
        frame({12'b0, 2'd1, 8'h9C, 2'd3, 8'h36}, 20);
        exp2[1] = 8'h9C;
        exp1[3] = 8'h36;
        chk_bank1("R8");
        for (int c = 0; c < 4; c++) chk("R8", {24'b0, codes2[c*8 +: 8]}, {24'b0, exp2[c]});
        chk("R8", {31'b0, sdo}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule